// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Self-Clearing Flush

This block holds the byte buffering between a register-bus front end and an I2C master shifter. It has two 8-bit queues. The transmit queue is filled from the bus side and drained by the shifter. The receive queue is filled by the shifter and drained by the bus side. Each queue reports its occupancy and a set of level flags for the interrupt logic. The transmit side also reports an overrun pulse. Each queue compares its occupancy against its own programmable 4-bit threshold. Transmit raises a near-empty flag and receive raises a near-full flag.

Software empties the queues by writing the control word. Bit 7 requests a transmit flush and bit 8 requests a receive flush, and both may be set in one write. A requested bit reads back as 1 for a fixed number of cycles and then clears itself. During that time the affected queue ignores pushes and pops. When the bit clears, the queue is empty.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset, both queues hold 0 bytes. `tx_empty` and `rx_empty` are 1, the full flags are 0, `tx_overrun` is 0 and both flush bits are 0. The transmit threshold resets to 0, so `tx_near_empty` is 1. The receive threshold resets to 1, so `rx_near_full` is 0.
- R2: Bytes leave each queue in the order they were accepted. The head byte is shown on `tx_head` or `rx_rdata` before it is popped. Each accepted push raises the level by one and each accepted pop lowers it by one. A push and a pop in the same cycle leave the level unchanged.
- R3: A queue is full at 16 bytes. A transmit push while full is dropped and its byte never appears at `tx_head`. That push makes `tx_overrun` high for exactly the one cycle after the clock edge that samples it.
- R4: A receive pop while empty leaves the level at 0, and `rx_rdata` reads 0 whenever the receive queue is empty. A receive push while full is dropped and leaves the level at 16.
- R5: `tx_near_empty` is 1 exactly when the transmit level is less than or equal to the transmit threshold. The threshold is loaded from `thr_wdata[3:0]` by `tx_thr_wr`, and all values 0 to 15 are legal.
- R6: `rx_near_full` is 1 exactly when the receive level is greater than or equal to the receive threshold. The threshold is loaded from `thr_wdata[3:0]` by `rx_thr_wr`.
- R7: A control write with bit 7 set starts a transmit flush, and a write with bit 8 set starts a receive flush. The flush status bit reads 1 for exactly 4 cycles after the sampling edge and then clears itself. A write with neither bit set starts nothing.
- R8: While a flush runs, pushes and pops of that queue are ignored. When the flush status bit clears, the queue's level is 0 and its empty flag is 1. Bytes pushed afterwards come out first.
- R9: A flush of one queue leaves the other queue's contents, level and push/pop handling unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word; bit 7 flushes transmit, bit 8 flushes receive |
| tx_thr_wr | input | 1 | Load transmit threshold |
| rx_thr_wr | input | 1 | Load receive threshold |
| thr_wdata | input | 4 | Threshold value |
| tx_push | input | 1 | Bus writes a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to enqueue for transmit |
| tx_pop | input | 1 | Shifter takes the transmit head byte |
| tx_head | output | 8 | Transmit head byte (0 when empty) |
| rx_push | input | 1 | Shifter stores a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Bus reads the receive head byte |
| rx_rdata | output | 8 | Receive head byte (0 when empty) |
| tx_level | output | 5 | Transmit occupancy |
| rx_level | output | 5 | Receive occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_near_empty | output | 1 | Transmit level at or below threshold |
| tx_full | output | 1 | Transmit queue full |
| tx_overrun | output | 1 | One-cycle pulse after a dropped transmit push |
| rx_empty | output | 1 | Receive queue empty |
| rx_near_full | output | 1 | Receive level at or above threshold |
| rx_full | output | 1 | Receive queue full |
| tx_flush_bit | output | 1 | Transmit flush in progress (control bit readback) |
| rx_flush_bit | output | 1 | Receive flush in progress (control bit readback) |

## Verification
The assertions assume that every strobe input is a known 0 or 1 in each cycle once reset is released. They also assume that reset is held long enough for the inputs to settle at 0. The overrun and flush-isolation properties look one cycle back, so they depend on the push, pop and level values of that previous cycle. The stimulus meets these assumptions by changing inputs only on falling clock edges. It holds every strobe at 0 during and right after reset, and raises each push, pop or write strobe for single whole cycles.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
  localparam int CMP_W = 8;

  function automatic logic lvl_at_or_below(input logic [CMP_W-1:0] lvl,
                                           input logic [CMP_W-1:0] thr);
    return lvl <= thr;
  endfunction

  function automatic logic lvl_at_or_above(input logic [CMP_W-1:0] lvl,
                                           input logic [CMP_W-1:0] thr);
    return lvl >= thr;
  endfunction
endpackage

// File: rtl/i2c_flush_seq.sv
module i2c_flush_seq #(
  parameter int FLUSH_CYC = 4,
  localparam int FW = $clog2(FLUSH_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic clear_now
);
  logic [FW-1:0] cnt;

  assign busy      = (cnt != '0);
  assign clear_now = (cnt == FW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (busy)         cnt <= cnt - FW'(1);
    else if (start)        cnt <= FW'(FLUSH_CYC);
  end

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_now |=> !busy);
endmodule

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          flushing,
  input  logic          clear_now,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] level,
  output logic          drop_push
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          is_full, is_empty, acc_push, acc_pop;

  assign is_full   = (cnt == CW'(DEPTH));
  assign is_empty  = (cnt == '0);
  assign acc_push  = push && !flushing && !is_full;
  assign acc_pop   = pop  && !flushing && !is_empty;
  assign drop_push = push && !flushing && is_full;
  assign level     = cnt;
  assign rdata     = is_empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (acc_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_now) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (acc_push) wr_ptr <= wr_ptr + AW'(1);
      if (acc_pop)  rd_ptr <= rd_ptr + AW'(1);
      cnt <= cnt + CW'(acc_push) - CW'(acc_pop);
    end
  end

  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  p_flush_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flushing && !clear_now) |=> $stable(level));
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_now |=> (level == '0));
  p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_push && !pop) |=> $stable(level));
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop && !push) |=> (level == '0));
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int THR_W        = 4,
  parameter int CTRL_W       = 16,
  parameter int FLUSH_CYC    = 4,
  parameter int TX_FLUSH_BIT = 7,
  parameter int RX_FLUSH_BIT = 8,
  parameter int TX_THR_RST   = 0,
  parameter int RX_THR_RST   = 1,
  localparam int CW          = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              tx_thr_wr,
  input  logic              rx_thr_wr,
  input  logic [THR_W-1:0]  thr_wdata,
  input  logic              tx_push,
  input  logic [7:0]        tx_wdata,
  input  logic              tx_pop,
  output logic [7:0]        tx_head,
  input  logic              rx_push,
  input  logic [7:0]        rx_wdata,
  input  logic              rx_pop,
  output logic [7:0]        rx_rdata,
  output logic [CW-1:0]     tx_level,
  output logic [CW-1:0]     rx_level,
  output logic              tx_empty,
  output logic              tx_near_empty,
  output logic              tx_full,
  output logic              tx_overrun,
  output logic              rx_empty,
  output logic              rx_near_full,
  output logic              rx_full,
  output logic              tx_flush_bit,
  output logic              rx_flush_bit
);
  localparam int LANES = 2;

  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [LANES-1:0] flush_start, flush_busy, flush_clear;
  logic             tx_drop, rx_drop, ovr_q;

  assign flush_start = {ctrl_wdata[RX_FLUSH_BIT], ctrl_wdata[TX_FLUSH_BIT]} & {LANES{ctrl_wr}};

  for (genvar g = 0; g < LANES; g++) begin : g_flush
    i2c_flush_seq #(.FLUSH_CYC(FLUSH_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (flush_start[g]),
      .busy     (flush_busy[g]),
      .clear_now(flush_clear[g])
    );
  end

  assign tx_flush_bit = flush_busy[0];
  assign rx_flush_bit = flush_busy[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= THR_W'(TX_THR_RST);
      rx_thr <= THR_W'(RX_THR_RST);
      ovr_q  <= 1'b0;
    end else begin
      if (tx_thr_wr) tx_thr <= thr_wdata;
      if (rx_thr_wr) rx_thr <= thr_wdata;
      ovr_q <= tx_drop;
    end
  end

  i2c_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .flushing(flush_busy[0]), .clear_now(flush_clear[0]),
    .rdata(tx_head), .level(tx_level), .drop_push(tx_drop)
  );

  i2c_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .flushing(flush_busy[1]), .clear_now(flush_clear[1]),
    .rdata(rx_rdata), .level(rx_level), .drop_push(rx_drop)
  );

  assign tx_overrun    = ovr_q;
  assign tx_empty      = (tx_level == '0);
  assign tx_full       = (tx_level == CW'(DEPTH));
  assign rx_empty      = (rx_level == '0);
  assign rx_full       = (rx_level == CW'(DEPTH));
  assign tx_near_empty = lvl_at_or_below(CMP_W'(tx_level), CMP_W'(tx_thr));
  assign rx_near_full  = lvl_at_or_above(CMP_W'(rx_level), CMP_W'(rx_thr));

  p_overrun_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |-> $past(tx_push && tx_full));
  p_rx_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (rx_rdata == 8'h00));
  p_rx_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_pop) |=> (rx_level == CW'(DEPTH)));
  p_isolate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_bit && !rx_flush_bit && rx_push && !rx_full && !rx_pop)
      |=> (rx_level == $past(rx_level) + CW'(1)));
endmodule

// File: tb/i2c_fifo_pair_test.sv
module i2c_fifo_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        tx_thr_wr = 1'b0, rx_thr_wr = 1'b0;
  logic [3:0]  thr_wdata = '0;
  logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0]  tx_wdata = '0, rx_wdata = '0;
  logic [7:0]  tx_head, rx_rdata;
  logic [4:0]  tx_level, rx_level;
  logic tx_empty, tx_near_empty, tx_full, tx_overrun;
  logic rx_empty, rx_near_full, rx_full, tx_flush_bit, rx_flush_bit;

  int n_chk = 0, n_fail = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #2.5 clk = ~clk;

  i2c_fifo_pair uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tx_put(input logic [7:0] b);
    tx_push = 1'b1; tx_wdata = b; cyc(); tx_push = 1'b0;
    if (txq.size() < 16) txq.push_back(b);
  endtask

  task automatic tx_take(input string tag);
    chk(tag, tx_head, txq.pop_front());
    tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    rx_push = 1'b1; rx_wdata = b; cyc(); rx_push = 1'b0;
    if (rxq.size() < 16) rxq.push_back(b);
  endtask

  task automatic rx_take(input string tag);
    if (rxq.size() == 0) chk(tag, rx_rdata, 0);
    else chk(tag, rx_rdata, rxq.pop_front());
    rx_pop = 1'b1; cyc(); rx_pop = 1'b0;
  endtask

  task automatic set_thr(input bit is_tx, input logic [3:0] v);
    thr_wdata = v;
    if (is_tx) tx_thr_wr = 1'b1; else rx_thr_wr = 1'b1;
    cyc(); tx_thr_wr = 1'b0; rx_thr_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 tx_level", tx_level, 0);   chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_empty", tx_empty, 1);   chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_full", tx_full, 0);     chk("R1 rx_full", rx_full, 0);
    chk("R1 overrun", tx_overrun, 0);
    chk("R1 flush bits", {tx_flush_bit, rx_flush_bit}, 0);
    chk("R1 tx_near_empty", tx_near_empty, 1);
    chk("R1 rx_near_full", rx_near_full, 0);

    // R2 ordering and levels, R5 threshold
    for (int i = 0; i < 5; i++) tx_put(8'h10 + 8'(i));
    chk("R2 tx_level after 5", tx_level, 5);
    chk("R5 near_empty thr0 lvl5", tx_near_empty, 0);
    set_thr(1'b1, 4'd5);
    chk("R5 near_empty thr5 lvl5", tx_near_empty, 1);
    set_thr(1'b1, 4'd4);
    chk("R5 near_empty thr4 lvl5", tx_near_empty, 0);
    chk("R2 head", tx_head, txq[0]);
    tx_pop = 1'b1; tx_push = 1'b1; tx_wdata = 8'hA5;
    void'(txq.pop_front()); txq.push_back(8'hA5);
    cyc(); tx_pop = 1'b0; tx_push = 1'b0;
    chk("R2 push+pop keeps level", tx_level, 5);
    while (txq.size() > 0) tx_take("R2 tx order");
    chk("R2 tx drained", tx_empty, 1);

    // R3 full and overrun
    set_thr(1'b1, 4'd15);
    for (int i = 0; i < 16; i++) tx_put(8'h40 + 8'(i));
    chk("R3 tx_full", tx_full, 1);
    chk("R5 near_empty lvl16 thr15", tx_near_empty, 0);
    chk("R3 no overrun yet", tx_overrun, 0);
    tx_put(8'hEE);
    chk("R3 overrun pulse", tx_overrun, 1);
    chk("R3 level stays 16", tx_level, 16);
    cyc();
    chk("R3 overrun one cycle", tx_overrun, 0);
    while (txq.size() > 0) tx_take("R3 dropped byte absent");
    chk("R3 empty after drain", tx_empty, 1);

    // R6 receive threshold, R4 empty read and full drop
    rx_put(8'h71);
    chk("R6 near_full thr1 lvl1", rx_near_full, 1);
    set_thr(1'b0, 4'd3);
    rx_put(8'h72);
    chk("R6 near_full thr3 lvl2", rx_near_full, 0);
    rx_put(8'h73);
    chk("R6 near_full thr3 lvl3", rx_near_full, 1);
    while (rxq.size() > 0) rx_take("R2 rx order");
    rx_take("R4 empty read zero");
    chk("R4 level after empty pop", rx_level, 0);
    for (int i = 0; i < 16; i++) rx_put(8'h80 + 8'(i));
    chk("R4 rx_full", rx_full, 1);
    rx_put(8'hDD);
    chk("R4 full drop level", rx_level, 16);
    while (rxq.size() > 0) rx_take("R4 dropped rx byte absent");

    // R7 R8 R9 transmit flush
    for (int i = 0; i < 3; i++) tx_put(8'h20 + 8'(i));
    for (int i = 0; i < 3; i++) rx_put(8'h30 + 8'(i));
    ctrl_wr = 1'b1; ctrl_wdata = 16'h0000; cyc(); ctrl_wr = 1'b0;
    chk("R7 no bits no flush", tx_flush_bit, 0);
    ctrl_wr = 1'b1; ctrl_wdata = 16'h0080; cyc(); ctrl_wr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R7 tx flush bit set", tx_flush_bit, 1);
      chk("R9 rx flush bit clear", rx_flush_bit, 0);
      tx_push = 1'b1; tx_wdata = 8'hCC;
      rx_push = (i == 0); rx_wdata = 8'h33;
      cyc();
      tx_push = 1'b0; rx_push = 1'b0;
      if (i == 0) rxq.push_back(8'h33);
    end
    chk("R7 tx flush self-clear", tx_flush_bit, 0);
    chk("R8 tx level zero", tx_level, 0);
    chk("R8 tx empty", tx_empty, 1);
    chk("R9 rx level kept", rx_level, 4);
    txq.delete();
    tx_put(8'h5A);
    tx_take("R8 fresh byte first");

    // R7 R8 both flushed in one write
    ctrl_wr = 1'b1; ctrl_wdata = 16'h0180; cyc(); ctrl_wr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R7 both bits set", {tx_flush_bit, rx_flush_bit}, 3);
      rx_pop = 1'b1; cyc(); rx_pop = 1'b0;
    end
    chk("R7 both self-clear", {tx_flush_bit, rx_flush_bit}, 0);
    chk("R8 rx level zero", rx_level, 0);
    chk("R8 rx empty read", rx_rdata, 0);
    rxq.delete();
    rx_put(8'h99);
    rx_take("R8 rx fresh byte first");

    summary();
    $finish;
  end
endmodule